// File: doc/BRIEF.md
# Circuit-Switched Link Source and Destination Endpoints

This block pairs two endpoint controllers on one unidirectional link that has already been set up through a circuit-switched network. The source endpoint takes words from its local core over a push interface with ready and valid. It sends them across a parallel data bus together with a Valid line and a per-word enable line. The destination endpoint controls a Request line that runs back to the source. It delivers each received word to its own core and reports how many words each transfer carried.

A transfer always starts at the receiver, which raises Request when its core can take data. The source answers by raising Valid and holding it high for the whole burst. Each word on the link comes with a one-cycle pulse of the enable line. When the source core has no word ready, Valid stays high, the data stays unchanged and the enable stays low. The core marks the final word with an end-of-burst flag. The source then lowers Valid. The destination answers by lowering Request, which closes the four-phase handshake. Both endpoints share one clock.

Top module: `link_pair`

## Requirements
- R1: The source raises link_valid_o only after link_req_o has been high for at least one clock cycle. Valid never stands high while Request is low.
- R2: While link_valid_o is high, the source puts one full DATA_W-bit word on link_data_o per cycle in which link_en_o is 1. The destination passes each such word unchanged to dst_word_o, with a one-cycle dst_word_valid_o pulse, in the order the source core pushed them.
- R3: The cycle after the word that carried src_last_i is on the link, link_valid_o goes to 0. The last word appears on dst_word_o in the same cycle that link_valid_o is first low.
- R4: One cycle after link_valid_o falls, link_req_o is 0 and dst_done_o pulses for one cycle.
- R5: link_req_o rises only after dst_ready_i has been high. While dst_ready_i is low and no transfer is open, link_req_o stays 0.
- R6: A word offered by the source core while src_ready_o is 0 is not taken. Link cycles with link_valid_o or link_en_o low deliver nothing to dst_word_o.
- R7: Between two bursts, link_req_o is seen at 0 after link_valid_o falls and before link_valid_o rises again.
- R8: In a stall inside a burst (the source core offers no word), link_valid_o stays 1, link_en_o is 0 and link_data_o keeps its previous value.
- R9: dst_count_o equals the number of words in the burst in the cycle that dst_done_o pulses. The count is taken modulo 2^CNT_W.
- R10: When reset is applied, link_valid_o, link_req_o, link_en_o, src_ready_o, dst_word_valid_o and dst_done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both endpoints |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Source core offers a word |
| src_data_i | input | DATA_W | Word offered by the source core |
| src_last_i | input | 1 | Offered word is the last of the burst |
| src_ready_o | output | 1 | Source endpoint takes the offered word at this edge |
| dst_ready_i | input | 1 | Destination core can accept a new transfer |
| dst_word_valid_o | output | 1 | One-cycle pulse: dst_word_o holds a received word |
| dst_word_o | output | DATA_W | Received word (output register) |
| dst_done_o | output | 1 | One-cycle pulse: transfer closed |
| dst_count_o | output | CNT_W | Number of words in the closed transfer |
| link_valid_o | output | 1 | Link Valid line, source to destination |
| link_en_o | output | 1 | Link per-word enable, source to destination |
| link_req_o | output | 1 | Link Request line, destination to source |
| link_data_o | output | DATA_W | Link data bus |

## Verification
The bench sends bursts that are back to back, that contain stalls in which junk data is offered without valid, that hold a single word, that use all-ones, all-zeros and alternating-bit words, and that run long. The back-to-back case checks ordering and the return to zero between bursts. The stalled case separates the per-word enable from Valid. Together they show that a pause is never taken for an end of burst and that junk never gets through. The single-word and long bursts check the end-of-burst timing and the word count at both edges. The extreme bit patterns expose any bit lane that is dropped or swapped. Holding the receiving core not ready, both before the first transfer and after a transfer, shows that Request alone gates the start.

// File: rtl/link_pair_pkg.sv
package link_pair_pkg;

    typedef enum logic [1:0] {
        TX_WAIT_LOW,
        TX_WAIT_HIGH,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_OPEN,
        RX_RECV
    } rx_state_e;

endpackage

// File: rtl/link_src.sv
module link_src
    import link_pair_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid_i,
    input  logic [DATA_W-1:0] core_data_i,
    input  logic              core_last_i,
    output logic              core_ready_o,
    input  logic              req_i,
    output logic              valid_o,
    output logic              en_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        tx_state_e         st;
        logic              valid;
        logic              en;
        logic [DATA_W-1:0] data;
    } src_regs_t;

    localparam src_regs_t SRC_RESET = '{
        st:    TX_WAIT_LOW,
        valid: 1'b0,
        en:    1'b0,
        data:  '0
    };

    src_regs_t q, d;

    always_comb begin
        d    = q;
        d.en = 1'b0;
        unique case (q.st)
            // return-to-zero: the Request of the last transfer must drop first
            TX_WAIT_LOW: begin
                d.valid = 1'b0;
                if (!req_i) begin
                    d.st = TX_WAIT_HIGH;
                end
            end
            TX_WAIT_HIGH: begin
                if (req_i) begin
                    d.st    = TX_SEND;
                    d.valid = 1'b1;
                end
            end
            TX_SEND: begin
                if (core_valid_i) begin
                    d.en   = 1'b1;
                    d.data = core_data_i;
                    if (core_last_i) begin
                        d.st = TX_WAIT_LOW;
                    end
                end
            end
            default: d = SRC_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SRC_RESET;
        end else begin
            q <= d;
        end
    end

    assign core_ready_o = (q.st == TX_SEND);
    assign valid_o      = q.valid;
    assign en_o         = q.en;
    assign data_o       = q.data;

endmodule

// File: rtl/link_dst.sv
module link_dst
    import link_pair_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_ready_i,
    input  logic              valid_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              req_o,
    output logic              word_valid_o,
    output logic [DATA_W-1:0] word_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o
);

    typedef struct packed {
        rx_state_e         st;
        logic              req;
        logic [CNT_W-1:0]  cnt;
        logic              wvalid;
        logic [DATA_W-1:0] word;
        logic              done;
        logic [CNT_W-1:0]  count;
    } dst_regs_t;

    localparam dst_regs_t DST_RESET = '{
        st:     RX_IDLE,
        req:    1'b0,
        cnt:    '0,
        wvalid: 1'b0,
        word:   '0,
        done:   1'b0,
        count:  '0
    };

    dst_regs_t q, d;
    logic      take;

    // a word is taken only inside an open transfer, with Valid and enable high
    assign take = valid_i && en_i && (q.st != RX_IDLE);

    always_comb begin
        d        = q;
        d.wvalid = 1'b0;
        d.done   = 1'b0;
        if (take) begin
            d.wvalid = 1'b1;
            d.word   = data_i;
            d.cnt    = q.cnt + 1'b1;
        end
        unique case (q.st)
            RX_IDLE: begin
                if (core_ready_i) begin
                    d.req = 1'b1;
                    d.cnt = '0;
                    d.st  = RX_OPEN;
                end
            end
            RX_OPEN: begin
                if (valid_i) begin
                    d.st = RX_RECV;
                end
            end
            RX_RECV: begin
                if (!valid_i) begin
                    d.req   = 1'b0;
                    d.done  = 1'b1;
                    d.count = q.cnt;
                    d.st    = RX_IDLE;
                end
            end
            default: d = DST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= DST_RESET;
        end else begin
            q <= d;
        end
    end

    assign req_o        = q.req;
    assign word_valid_o = q.wvalid;
    assign word_o       = q.word;
    assign done_o       = q.done;
    assign count_o      = q.count;

endmodule

// File: rtl/link_pair.sv
module link_pair #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic              src_last_i,
    output logic              src_ready_o,
    input  logic              dst_ready_i,
    output logic              dst_word_valid_o,
    output logic [DATA_W-1:0] dst_word_o,
    output logic              dst_done_o,
    output logic [CNT_W-1:0]  dst_count_o,
    output logic              link_valid_o,
    output logic              link_en_o,
    output logic              link_req_o,
    output logic [DATA_W-1:0] link_data_o
);

    logic              lk_valid;
    logic              lk_en;
    logic              lk_req;
    logic [DATA_W-1:0] lk_data;

    link_src #(.DATA_W(DATA_W)) u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_valid_i (src_valid_i),
        .core_data_i  (src_data_i),
        .core_last_i  (src_last_i),
        .core_ready_o (src_ready_o),
        .req_i        (lk_req),
        .valid_o      (lk_valid),
        .en_o         (lk_en),
        .data_o       (lk_data)
    );

    link_dst #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dst (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_ready_i (dst_ready_i),
        .valid_i      (lk_valid),
        .en_i         (lk_en),
        .data_i       (lk_data),
        .req_o        (lk_req),
        .word_valid_o (dst_word_valid_o),
        .word_o       (dst_word_o),
        .done_o       (dst_done_o),
        .count_o      (dst_count_o)
    );

    assign link_valid_o = lk_valid;
    assign link_en_o    = lk_en;
    assign link_req_o   = lk_req;
    assign link_data_o  = lk_data;

endmodule

// File: rtl/link_pair_chk.sv
module link_pair_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dst_ready_i,
    input logic              dst_done_o,
    input logic              link_valid_o,
    input logic              link_en_o,
    input logic              link_req_o,
    input logic [DATA_W-1:0] link_data_o
);

    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_valid_o) |-> (link_req_o && $past(link_req_o)));

    a_r1_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid_o |-> link_req_o);

    a_r2_enable_inside_valid: assert property (@(posedge clk) disable iff (!rst_n)
        link_en_o |-> link_valid_o);

    a_r4_req_drops_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_valid_o) |=> (!link_req_o && dst_done_o));

    a_r7_req_falls_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_req_o) |-> !$past(link_valid_o));

    a_r5_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_req_o) |-> $past(dst_ready_i));

    a_r8_stall_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid_o && !link_en_o && $past(link_valid_o)) |-> $stable(link_data_o));

    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!link_valid_o && !link_req_o && !link_en_o));

endmodule

bind link_pair link_pair_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dst_ready_i  (dst_ready_i),
    .dst_done_o   (dst_done_o),
    .link_valid_o (link_valid_o),
    .link_en_o    (link_en_o),
    .link_req_o   (link_req_o),
    .link_data_o  (link_data_o)
);

// File: tb/link_pair_test.sv
module link_pair_test;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int MAXW   = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_valid_i = 1'b0;
    logic [DATA_W-1:0] src_data_i = '0;
    logic              src_last_i = 1'b0;
    logic              src_ready_o;
    logic              dst_ready_i = 1'b0;
    logic              dst_word_valid_o;
    logic [DATA_W-1:0] dst_word_o;
    logic              dst_done_o;
    logic [CNT_W-1:0]  dst_count_o;
    logic              link_valid_o;
    logic              link_en_o;
    logic              link_req_o;
    logic [DATA_W-1:0] link_data_o;

    always #5 clk = ~clk;

    link_pair #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .src_valid_i      (src_valid_i),
        .src_data_i       (src_data_i),
        .src_last_i       (src_last_i),
        .src_ready_o      (src_ready_o),
        .dst_ready_i      (dst_ready_i),
        .dst_word_valid_o (dst_word_valid_o),
        .dst_word_o       (dst_word_o),
        .dst_done_o       (dst_done_o),
        .dst_count_o      (dst_count_o),
        .link_valid_o     (link_valid_o),
        .link_en_o        (link_en_o),
        .link_req_o       (link_req_o),
        .link_data_o      (link_data_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // link monitor, sampled away from the active edge
    logic [DATA_W-1:0] rx [MAXW];
    int                rx_n = 0;
    int                last_rx_cyc = -1;
    int                fall_cyc = -1;
    int                r1_bad = 0;
    int                r7_bad = 0;
    int                r8_bad = 0;
    logic              need_low = 1'b0;
    logic              prev_valid = 1'b0;
    logic [DATA_W-1:0] prev_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dst_word_valid_o) begin
                if (rx_n < MAXW) rx[rx_n] = dst_word_o;
                rx_n = rx_n + 1;
                last_rx_cyc = cyc;
            end
            if (link_valid_o && !link_req_o) r1_bad = r1_bad + 1;
            if (prev_valid && !link_valid_o) begin
                fall_cyc = cyc;
                need_low = 1'b1;
            end
            if (!link_req_o) need_low = 1'b0;
            if (!prev_valid && link_valid_o && need_low) r7_bad = r7_bad + 1;
            if (prev_valid && link_valid_o && !link_en_o && link_data_o != prev_data)
                r8_bad = r8_bad + 1;
        end
        prev_valid = link_valid_o;
        prev_data  = link_data_o;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] word_of(input int mode, input int seed, input int i);
        logic [DATA_W-1:0] w;
        if (mode == 1) begin
            case (i % 4)
                0: w = '1;
                1: w = '0;
                2: w = {(DATA_W/2){2'b10}};
                default: w = {(DATA_W/2){2'b01}};
            endcase
        end else begin
            w = DATA_W'(seed + i * 16'h1357);
        end
        return w;
    endfunction

    // one burst of n words; gap>0 inserts stalls with junk data before odd words
    task automatic run_burst(input string name, input int n, input int gap,
                             input int mode, input int seed, input bit drop_ready);
        int base;
        int bad;
        int waitc;
        int b1;
        int b8;
        base = rx_n;
        b1 = r1_bad;
        b8 = r8_bad;
        @(negedge clk);
        if (drop_ready) dst_ready_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % 2) == 1) begin
                for (int g = 0; g < gap; g++) begin
                    src_valid_i = 1'b0;
                    src_data_i  = DATA_W'(16'hDEAD ^ i ^ g);
                    src_last_i  = 1'b1;
                    @(negedge clk);
                end
            end
            src_valid_i = 1'b1;
            src_data_i  = word_of(mode, seed, i);
            src_last_i  = (i == n - 1);
            waitc = 0;
            while (!src_ready_o && waitc < 1000) begin
                @(negedge clk);
                waitc++;
            end
            @(negedge clk);
        end
        src_valid_i = 1'b0;
        src_last_i  = 1'b0;
        src_data_i  = DATA_W'(16'hBEEF);
        waitc = 0;
        while (!dst_done_o && waitc < 1000) begin
            @(negedge clk);
            waitc++;
        end
        // R9: count reported with the done pulse
        check(dst_done_o && dst_count_o == CNT_W'(n), {"R9 count ", name}, dst_count_o, n);
        // R4: done one cycle after Valid fell, with Request low
        check(cyc == fall_cyc + 1 && !link_req_o, {"R4 close ", name}, cyc - fall_cyc, 1);
        // R3: last word delivered in the first cycle Valid is low
        check(last_rx_cyc == fall_cyc, {"R3 end timing ", name}, last_rx_cyc, fall_cyc);
        // R2 / R6: exact words, in order, nothing extra
        bad = 0;
        for (int i = 0; i < n; i++)
            if (rx[base + i] != word_of(mode, seed, i)) bad++;
        check(rx_n - base == n && bad == 0, {"R2 R6 words ", name}, rx_n - base, n);
        check(r1_bad == b1, {"R1 valid under request ", name}, r1_bad - b1, 0);
        if (gap > 0)
            check(r8_bad == b8, {"R8 stall hold ", name}, r8_bad - b8, 0);
        if (drop_ready) begin
            // R5: no new Request while the core is not ready
            bad = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (link_req_o || src_ready_o) bad++;
            end
            check(bad == 0, {"R5 held off ", name}, bad, 0);
            dst_ready_i = 1'b1;
        end
    endtask

    task automatic test_reset();
        check(!link_valid_o && !link_req_o && !link_en_o, "R10 link idle",
              {link_valid_o, link_req_o, link_en_o}, 0);
        check(!src_ready_o && !dst_word_valid_o && !dst_done_o, "R10 cores idle",
              {src_ready_o, dst_word_valid_o, dst_done_o}, 0);
    endtask

    task automatic test_not_ready();
        int bad;
        int base;
        base = rx_n;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            src_valid_i = 1'b1;
            src_data_i  = DATA_W'(16'hA5A5 + k);
            src_last_i  = 1'b1;
            if (link_req_o || src_ready_o || link_valid_o) bad++;
        end
        check(bad == 0, "R5 no request before ready", bad, 0);
        check(rx_n == base, "R6 offered word not taken", rx_n - base, 0);
        @(negedge clk);
        src_valid_i = 1'b0;
        dst_ready_i = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        checks = checks + 1;
        failures = failures + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_not_ready();
        run_burst("single", 1, 0, 0, 16'h0042, 1'b0);
        run_burst("back to back", 8, 0, 0, 16'h1000, 1'b0);
        run_burst("stalled", 7, 3, 0, 16'h7000, 1'b0);
        run_burst("bit patterns", 8, 1, 1, 0, 1'b0);
        run_burst("ready dropped", 3, 0, 0, 16'h3300, 1'b1);
        run_burst("long", 40, 0, 0, 16'h0101, 1'b0);
        // R7: Request returned to zero before every new burst
        check(r7_bad == 0, "R7 return to zero", r7_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule